// File: doc/BRIEF.md
# Multi-Channel DAC Control Register Slave

This block is the digital control port of a multi-channel digital-to-analog converter. An external SPI master sends 24-bit frames. Each frame carries a 2-bit command, a 6-bit address and a 16-bit payload. The commands write per-channel code, offset-trim and gain-trim registers. They also reach a small set of special-function registers: a no-operation slot, a control word, one 14-bit offset per reference group, and a readback selector. All register contents go out as parallel buses to the converter core, together with a power-down flag.

Channels are organised into groups, and each group shares one reference and therefore one group offset register. Groups numbered past the last reference all fold onto the last one. Every channel gets its effective group offset on a per-channel bus.

Reading takes two frames. A readback-select frame names a register. The next frame shifts that register's value out on MISO, whatever that next frame writes.

The SPI pins are sampled in the system clock domain through synchronisers. The SPI clock therefore has to be several times slower than the system clock. At most three reference groups are supported, and at most 56 channels.

Top module: `dacspi_slave`

## Requirements
- R1: SPI mode 0, MSB first. A frame is acted on when chip select rises, and only if exactly 24 rising SCLK edges were seen while chip select was low. A frame with any other bit count changes no register and leaves the pending readback value as it was.
- R2: Command 3 (frame bits 23:22) writes the payload (bits 15:0) into the code register of channel n when the address (bits 21:16) equals n+8.
- R3: Command 2 writes the channel offset-trim register, and command 1 writes the channel gain-trim register. Both use the same n+8 addressing.
- R4: A channel command whose address is below 8 or at least 8+NUM_CH changes nothing. A special-function frame to an address that is not 1, 2..1+NUM_REFS or 5 changes nothing, and this includes the no-operation address 0.
- R5: Command 0 at address 1 stores the 16-bit control word. Its bit 0 drives the pwr_down output.
- R6: Command 0 at address 2+g stores payload bits 13:0 into the offset register of reference group g.
- R7: Channel n uses the group offset of group min(n / CH_PER_GRP, NUM_REFS-1). This value appears on its slice of ch_grp_ofs.
- R8: Command 0 at address 5 is a readback select. Bits 15:13 give the type and bits 12:7 give the address. Type 0 returns the channel code, type 2 the channel offset, type 3 the channel gain, and type 4 the special-function register (control, or a zero-extended group offset). The selected value is shifted out in the low 16 bits of the next frame, and the upper 8 bits of that frame are 0.
- R9: Any accepted frame other than a readback select makes the next frame return 0. Readback of type 1, of types 5 to 7, and of any unmapped address also returns 0.
- R10: After reset the channel codes are 0, the channel offsets are 0x8000, the gains are all ones (within the code width), the group offsets are 0x2000, control is 0, and the first frame returns 0.
- R11: With CODE_BITS below 16, channel codes are left-justified. The low 16-CODE_BITS bits of every channel code, offset and gain register always read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | SPI clock, idle low |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Serial data in |
| spi_miso | output | 1 | Serial data out |
| ch_data | output | NUM_CH*16 | Channel codes, channel n at [16n+15:16n] |
| ch_ofs | output | NUM_CH*16 | Channel offset trims |
| ch_gain | output | NUM_CH*16 | Channel gain trims |
| grp_ofs | output | NUM_REFS*14 | Group offset registers |
| ch_grp_ofs | output | NUM_CH*14 | Effective group offset of each channel |
| pwr_down | output | 1 | Control bit 0 |

## Verification
A wrong decode or write enable shows on the parallel buses a few system clocks after chip select rises. The bench compares every bus against its own model after every frame, so such an error is caught within one frame. A wrong readback path or wrong pending value only shows on MISO during the frame that follows. Every frame's response is therefore checked against the model's pending value. Short and long frames are mixed into the stimulus, so a miscounted frame shows as a corrupted bus or a changed response at the next check.

// File: rtl/dacspi_pkg.sv
package dacspi_pkg;
    localparam int FRAME_W = 24;
    localparam int REG_W   = 16;
    localparam int GOFS_W  = 14;
    localparam int ADDR_W  = 6;
    localparam int CH_BASE = 8;

    typedef enum logic [1:0] {
        OP_SPECIAL = 2'd0,
        OP_GAIN    = 2'd1,
        OP_OFFSET  = 2'd2,
        OP_CODE    = 2'd3
    } op_e;

    localparam logic [ADDR_W-1:0] SF_CTRL  = 6'd1;
    localparam logic [ADDR_W-1:0] SF_GOFS0 = 6'd2;
    localparam logic [ADDR_W-1:0] SF_RDSEL = 6'd5;

    localparam logic [2:0] RD_CODE   = 3'd0;
    localparam logic [2:0] RD_OFFSET = 3'd2;
    localparam logic [2:0] RD_GAIN   = 3'd3;
    localparam logic [2:0] RD_SPECIAL = 3'd4;

    localparam logic [REG_W-1:0]  RST_OFS  = 16'h8000;
    localparam logic [GOFS_W-1:0] RST_GOFS = 14'h2000;
endpackage

// File: rtl/dacspi_shift.sv
module dacspi_shift
    import dacspi_pkg::*;
#(
    parameter int SYNC = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sclk,
    input  logic               cs_n,
    input  logic               mosi,
    input  logic [REG_W-1:0]   rb_data,
    output logic               frame_vld,
    output logic [FRAME_W-1:0] frame,
    output logic               miso
);
    localparam int CNT_W = $clog2(FRAME_W + 2);
    localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(FRAME_W + 1);

    typedef struct packed {
        logic [SYNC:0]        sclk_h;
        logic [SYNC:0]        cs_h;
        logic [SYNC-1:0]      mosi_h;
        logic [FRAME_W-1:0]   rx;
        logic [FRAME_W-1:0]   tx;
        logic [CNT_W-1:0]     cnt;
        logic                 vld;
    } fe_t;

    fe_t st_d, st_q;
    logic sclk_rise, sclk_fall, cs_rise, cs_fall, cs_act, mosi_s;

    always_comb begin
        st_d = st_q;
        st_d.sclk_h = (SYNC+1)'({st_q.sclk_h, sclk});
        st_d.cs_h   = (SYNC+1)'({st_q.cs_h, cs_n});
        st_d.mosi_h = SYNC'({st_q.mosi_h, mosi});
        st_d.vld    = 1'b0;

        sclk_rise = st_q.sclk_h[SYNC-1] & ~st_q.sclk_h[SYNC];
        sclk_fall = ~st_q.sclk_h[SYNC-1] & st_q.sclk_h[SYNC];
        cs_rise   = st_q.cs_h[SYNC-1] & ~st_q.cs_h[SYNC];
        cs_fall   = ~st_q.cs_h[SYNC-1] & st_q.cs_h[SYNC];
        cs_act    = ~st_q.cs_h[SYNC-1];
        mosi_s    = st_q.mosi_h[SYNC-1];

        if (cs_fall) begin
            st_d.cnt = '0;
            st_d.tx  = {{(FRAME_W-REG_W){1'b0}}, rb_data};
        end else if (cs_act) begin
            if (sclk_rise) begin
                st_d.rx = {st_q.rx[FRAME_W-2:0], mosi_s};
                if (st_q.cnt != CNT_SAT) st_d.cnt = st_q.cnt + 1'b1;
            end
            if (sclk_fall) st_d.tx = {st_q.tx[FRAME_W-2:0], 1'b0};
        end
        if (cs_rise) st_d.vld = (st_q.cnt == CNT_W'(FRAME_W));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.cs_h   <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign frame_vld = st_q.vld;
    assign frame     = st_q.rx;
    assign miso      = st_q.tx[FRAME_W-1];
endmodule

// File: rtl/dacspi_regs.sv
module dacspi_regs
    import dacspi_pkg::*;
#(
    parameter int NUM_CH     = 24,
    parameter int CH_PER_GRP = 8,
    parameter int NUM_REFS   = 2,
    parameter int CODE_BITS  = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        frame_vld,
    input  logic [FRAME_W-1:0]          frame,
    output logic [NUM_CH*REG_W-1:0]     ch_data,
    output logic [NUM_CH*REG_W-1:0]     ch_ofs,
    output logic [NUM_CH*REG_W-1:0]     ch_gain,
    output logic [NUM_REFS*GOFS_W-1:0]  grp_ofs,
    output logic [NUM_CH*GOFS_W-1:0]    ch_grp_ofs,
    output logic                        pwr_down,
    output logic [REG_W-1:0]            rb_data
);
    localparam logic [REG_W-1:0] CODE_MASK = REG_W'({REG_W{1'b1}} << (REG_W - CODE_BITS));

    typedef struct packed {
        logic [NUM_CH-1:0][REG_W-1:0]    data;
        logic [NUM_CH-1:0][REG_W-1:0]    ofs;
        logic [NUM_CH-1:0][REG_W-1:0]    gain;
        logic [NUM_REFS-1:0][GOFS_W-1:0] gofs;
        logic [REG_W-1:0]                ctrl;
        logic [REG_W-1:0]                rb;
    } regs_t;

    regs_t rg_d, rg_q;
    op_e               op;
    logic [ADDR_W-1:0] addr, rd_addr;
    logic [REG_W-1:0]  pay, rd_val;
    logic [2:0]        rd_type;

    always_comb begin
        rg_d    = rg_q;
        op      = op_e'(frame[23:22]);
        addr    = frame[21:16];
        pay     = frame[15:0];
        rd_type = frame[15:13];
        rd_addr = frame[12:7];

        rd_val = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (rd_addr == ADDR_W'(CH_BASE + i)) begin
                case (rd_type)
                    RD_CODE:   rd_val = rg_q.data[i];
                    RD_OFFSET: rd_val = rg_q.ofs[i];
                    RD_GAIN:   rd_val = rg_q.gain[i];
                    default:   ;
                endcase
            end
        end
        if (rd_type == RD_SPECIAL) begin
            if (rd_addr == SF_CTRL) rd_val = rg_q.ctrl;
            for (int g = 0; g < NUM_REFS; g++)
                if (rd_addr == SF_GOFS0 + ADDR_W'(g))
                    rd_val = {{(REG_W-GOFS_W){1'b0}}, rg_q.gofs[g]};
        end

        if (frame_vld) begin
            for (int i = 0; i < NUM_CH; i++) begin
                if (addr == ADDR_W'(CH_BASE + i)) begin
                    case (op)
                        OP_CODE:   rg_d.data[i] = pay & CODE_MASK;
                        OP_OFFSET: rg_d.ofs[i]  = pay & CODE_MASK;
                        OP_GAIN:   rg_d.gain[i] = pay & CODE_MASK;
                        default:   ;
                    endcase
                end
            end
            if (op == OP_SPECIAL) begin
                if (addr == SF_CTRL) rg_d.ctrl = pay;
                for (int g = 0; g < NUM_REFS; g++)
                    if (addr == SF_GOFS0 + ADDR_W'(g)) rg_d.gofs[g] = pay[GOFS_W-1:0];
            end
            rg_d.rb = (op == OP_SPECIAL && addr == SF_RDSEL) ? rd_val : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_CH; i++) begin
                rg_q.data[i] <= '0;
                rg_q.ofs[i]  <= RST_OFS & CODE_MASK;
                rg_q.gain[i] <= CODE_MASK;
            end
            for (int g = 0; g < NUM_REFS; g++) rg_q.gofs[g] <= RST_GOFS;
            rg_q.ctrl <= '0;
            rg_q.rb   <= '0;
        end else begin
            rg_q <= rg_d;
        end
    end

    for (genvar n = 0; n < NUM_CH; n++) begin : g_grp
        localparam int GRP = (n / CH_PER_GRP < NUM_REFS) ? n / CH_PER_GRP : NUM_REFS - 1;
        assign ch_grp_ofs[n*GOFS_W +: GOFS_W] = rg_q.gofs[GRP];
    end

    assign ch_data  = rg_q.data;
    assign ch_ofs   = rg_q.ofs;
    assign ch_gain  = rg_q.gain;
    assign grp_ofs  = rg_q.gofs;
    assign pwr_down = rg_q.ctrl[0];
    assign rb_data  = rg_q.rb;
endmodule

// File: rtl/dacspi_slave.sv
module dacspi_slave
    import dacspi_pkg::*;
#(
    parameter int NUM_CH     = 24,
    parameter int CH_PER_GRP = 8,
    parameter int NUM_REFS   = 2,
    parameter int CODE_BITS  = 16,
    parameter int SYNC       = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          spi_sclk,
    input  logic                          spi_cs_n,
    input  logic                          spi_mosi,
    output logic                          spi_miso,
    output logic [NUM_CH*16-1:0]          ch_data,
    output logic [NUM_CH*16-1:0]          ch_ofs,
    output logic [NUM_CH*16-1:0]          ch_gain,
    output logic [NUM_REFS*14-1:0]        grp_ofs,
    output logic [NUM_CH*14-1:0]          ch_grp_ofs,
    output logic                          pwr_down
);
    logic               frame_vld;
    logic [FRAME_W-1:0] frame;
    logic [REG_W-1:0]   rb_data;

    dacspi_shift #(.SYNC(SYNC)) u_shift (
        .clk(clk), .rst_n(rst_n), .sclk(spi_sclk), .cs_n(spi_cs_n), .mosi(spi_mosi),
        .rb_data(rb_data), .frame_vld(frame_vld), .frame(frame), .miso(spi_miso)
    );

    dacspi_regs #(
        .NUM_CH(NUM_CH), .CH_PER_GRP(CH_PER_GRP), .NUM_REFS(NUM_REFS), .CODE_BITS(CODE_BITS)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .frame_vld(frame_vld), .frame(frame),
        .ch_data(ch_data), .ch_ofs(ch_ofs), .ch_gain(ch_gain), .grp_ofs(grp_ofs),
        .ch_grp_ofs(ch_grp_ofs), .pwr_down(pwr_down), .rb_data(rb_data)
    );
endmodule

// File: rtl/dacspi_checker.sv
module dacspi_checker #(
    parameter int NUM_CH    = 24,
    parameter int NUM_REFS  = 2,
    parameter int CODE_BITS = 16
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   frame_vld,
    input logic [NUM_CH*16-1:0]   ch_data,
    input logic [NUM_CH*16-1:0]   ch_ofs,
    input logic [NUM_CH*16-1:0]   ch_gain,
    input logic [NUM_REFS*14-1:0] grp_ofs,
    input logic                   pwr_down
);
    localparam logic [15:0] LOW_MASK = 16'(~(16'hFFFF << (16 - CODE_BITS)));

    // R1, R4: register state moves only in the cycle after an accepted frame
    assert_regs_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_vld |=> ($stable(ch_data) && $stable(ch_ofs) && $stable(ch_gain)
                        && $stable(grp_ofs) && $stable(pwr_down)))
        else $error("registers changed without an accepted frame");

    // R1: an accepted frame is a single-cycle event
    assert_single_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
        frame_vld |=> !frame_vld)
        else $error("frame strobe longer than one cycle");

    // R5: power-down turns on only as a result of a frame
    assert_pwr_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwr_down) |-> $past(frame_vld))
        else $error("power-down set without a frame");

    // R6: group offsets only move on a frame
    assert_gofs_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(frame_vld) |-> $stable(grp_ofs))
        else $error("group offset changed without a frame");

    // R11: justified codes keep their low bits clear
    always @(posedge clk) begin
        if (rst_n) begin
            for (int i = 0; i < NUM_CH; i++) begin
                assert_lsb_zero_R11: assert (((ch_data[i*16 +: 16] | ch_ofs[i*16 +: 16]
                                               | ch_gain[i*16 +: 16]) & LOW_MASK) == 16'h0)
                    else $error("low code bits set on channel %0d", i);
            end
        end
    end
endmodule

bind dacspi_slave dacspi_checker #(
    .NUM_CH(NUM_CH), .NUM_REFS(NUM_REFS), .CODE_BITS(CODE_BITS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .frame_vld(frame_vld), .ch_data(ch_data), .ch_ofs(ch_ofs),
    .ch_gain(ch_gain), .grp_ofs(grp_ofs), .pwr_down(pwr_down)
);

// File: tb/dacspi_slave_bench.sv
module dacspi_slave_bench;
    localparam int NUM_CH = 24;
    localparam int CPG    = 8;
    localparam int NREF   = 2;
    localparam int CB     = 14;
    localparam logic [15:0] MASK = 16'(16'hFFFF << (16 - CB));

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
    logic miso, pwr_down;
    logic [NUM_CH*16-1:0] ch_data, ch_ofs, ch_gain;
    logic [NREF*14-1:0]   grp_ofs;
    logic [NUM_CH*14-1:0] ch_grp_ofs;

    always #10 clk = ~clk;

    dacspi_slave #(.NUM_CH(NUM_CH), .CH_PER_GRP(CPG), .NUM_REFS(NREF), .CODE_BITS(CB)) u_dacspi_slave (
        .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi),
        .spi_miso(miso), .ch_data(ch_data), .ch_ofs(ch_ofs), .ch_gain(ch_gain),
        .grp_ofs(grp_ofs), .ch_grp_ofs(ch_grp_ofs), .pwr_down(pwr_down)
    );

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    logic [15:0] m_data [NUM_CH];
    logic [15:0] m_ofs  [NUM_CH];
    logic [15:0] m_gain [NUM_CH];
    logic [13:0] m_gofs [NREF];
    logic [15:0] m_ctrl, m_rb;

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(string tag, logic [511:0] got, logic [511:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic xfer(input logic [23:0] w, input int nb, output logic [23:0] r);
        r = '0;
        cs_n = 1'b0;
        tick(6);
        for (int b = 0; b < nb; b++) begin
            mosi = (b < 24) ? w[23-b] : 1'b0;
            tick(4);
            sclk = 1'b1;
            r = {r[22:0], miso};
            tick(4);
            sclk = 1'b0;
        end
        tick(6);
        cs_n = 1'b1;
        tick(10);
    endtask

    function automatic logic [15:0] lookup(logic [2:0] t, logic [5:0] a);
        int ch = int'(a) - 8;
        bit in_ch = (a >= 8) && (ch < NUM_CH);
        case (t)
            3'd0: return in_ch ? m_data[ch] : 16'h0;
            3'd2: return in_ch ? m_ofs[ch]  : 16'h0;
            3'd3: return in_ch ? m_gain[ch] : 16'h0;
            3'd4: begin
                if (a == 6'd1) return m_ctrl;
                if (a >= 2 && a < 2 + NREF) return {2'b00, m_gofs[a-2]};
                return 16'h0;
            end
            default: return 16'h0;
        endcase
    endfunction

    task automatic apply(logic [23:0] w);
        logic [1:0]  c = w[23:22];
        logic [5:0]  a = w[21:16];
        logic [15:0] p = w[15:0];
        logic [15:0] nrb = (c == 2'd0 && a == 6'd5) ? lookup(p[15:13], p[12:7]) : 16'h0;
        bit in_ch = (a >= 8) && (a < 8 + NUM_CH);
        case (c)
            2'd3: if (in_ch) m_data[a-8] = p & MASK;
            2'd2: if (in_ch) m_ofs[a-8]  = p & MASK;
            2'd1: if (in_ch) m_gain[a-8] = p & MASK;
            default: begin
                if (a == 6'd1) m_ctrl = p;
                else if (a >= 2 && a < 2 + NREF) m_gofs[a-2] = p[13:0];
            end
        endcase
        m_rb = nrb;
    endtask

    task automatic check_state(string tag);
        logic [NUM_CH*16-1:0] ed, eo, eg;
        logic [NREF*14-1:0]   egr;
        logic [NUM_CH*14-1:0] ecg;
        for (int i = 0; i < NUM_CH; i++) begin
            int g = i / CPG;
            if (g > NREF - 1) g = NREF - 1;
            ed[i*16 +: 16] = m_data[i];
            eo[i*16 +: 16] = m_ofs[i];
            eg[i*16 +: 16] = m_gain[i];
            ecg[i*14 +: 14] = m_gofs[g];
        end
        for (int g = 0; g < NREF; g++) egr[g*14 +: 14] = m_gofs[g];
        chk({tag, " code"}, 512'(ch_data), 512'(ed));
        chk({tag, " offset"}, 512'(ch_ofs), 512'(eo));
        chk({tag, " gain"}, 512'(ch_gain), 512'(eg));
        chk({tag, " group offset"}, 512'(grp_ofs), 512'(egr));
        chk({tag, " R7 channel group offset"}, 512'(ch_grp_ofs), 512'(ecg));
        chk({tag, " R5 power-down"}, 512'(pwr_down), 512'(m_ctrl[0]));
    endtask

    task automatic frame(logic [23:0] w, string tag);
        logic [23:0] r;
        xfer(w, 24, r);
        chk({tag, " R8 response"}, 512'(r), 512'({8'h00, m_rb}));
        apply(w);
        check_state(tag);
    endtask

    function automatic logic [23:0] mk(logic [1:0] c, logic [5:0] a, logic [15:0] p);
        return {c, a, p};
    endfunction

    function automatic logic [23:0] rdsel(logic [2:0] t, logic [5:0] a);
        return {2'd0, 6'd5, t, a, 7'd0};
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [23:0] r;
        void'($urandom(32'd4711));
        for (int i = 0; i < NUM_CH; i++) begin
            m_data[i] = 16'h0;
            m_ofs[i]  = 16'h8000 & MASK;
            m_gain[i] = MASK;
        end
        for (int g = 0; g < NREF; g++) m_gofs[g] = 14'h2000;
        m_ctrl = 16'h0;
        m_rb   = 16'h0;

        tick(5);
        rst_n = 1'b1;
        tick(5);
        check_state("R10 reset");

        frame(mk(2'd3, 6'd8, 16'hABCD), "R2 code ch0");
        frame(mk(2'd3, 6'd31, 16'h1237), "R2 code last ch");
        frame(rdsel(3'd0, 6'd31), "R8 select code");
        frame(mk(2'd0, 6'd0, 16'hFFFF), "R9 nop after read");
        frame(mk(2'd0, 6'd0, 16'h0000), "R9 response after nop");
        frame(mk(2'd2, 6'd12, 16'h4321), "R3 offset");
        frame(mk(2'd1, 6'd13, 16'h7777), "R3 gain");
        frame(rdsel(3'd3, 6'd13), "R8 select gain");
        frame(rdsel(3'd1, 6'd8), "R9 type 1");
        frame(mk(2'd3, 6'd32, 16'h5555), "R4 beyond last ch");
        frame(mk(2'd3, 6'd7, 16'h5555), "R4 below first ch");
        frame(mk(2'd0, 6'd4, 16'h5555), "R4 unmapped special");
        frame(mk(2'd0, 6'd2, 16'hC123), "R6 group 0");
        frame(mk(2'd0, 6'd3, 16'h0ABC), "R6 group 1 folded R7");
        frame(rdsel(3'd4, 6'd3), "R8 select group offset");
        frame(mk(2'd0, 6'd1, 16'h0001), "R5 power down on");
        frame(rdsel(3'd4, 6'd1), "R8 select control");
        frame(mk(2'd0, 6'd1, 16'h0000), "R5 power down off");
        frame(rdsel(3'd2, 6'd12), "R8 select offset");
        xfer(mk(2'd3, 6'd9, 16'hFFFF), 23, r);
        tick(4);
        check_state("R1 short frame");
        xfer(mk(2'd3, 6'd9, 16'hFFFF), 25, r);
        tick(4);
        check_state("R1 long frame");
        frame(mk(2'd0, 6'd0, 16'h0), "R1 pending kept R9");
        frame(mk(2'd3, 6'd9, 16'hFFFF), "R11 justified code");

        for (int k = 0; k < 280; k++) begin
            int kind = int'($urandom % 10);
            if (kind < 7) begin
                frame(mk(2'($urandom), 6'($urandom % 40), 16'($urandom)), "R2 R3 random");
            end else if (kind < 9) begin
                logic [2:0] t = 3'($urandom);
                logic [5:0] a = (t == 3'd4) ? 6'($urandom % 8) : 6'($urandom % 40);
                frame(rdsel(t, a), "R8 random select");
            end else begin
                xfer(24'($urandom), ($urandom % 2) ? 23 : 25, r);
                tick(4);
                check_state("R1 random bad length");
            end
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule